// File: doc/BRIEF.md
# Processor Reset and Strap Sequencer

This block produces the active-low reset for the host processor and sequences the bus-request strap that the processor samples as its reset is released. A platform reset, which may arrive asynchronously, pulls the processor reset low at once. When the platform reset is released, the block keeps the processor reset low for a further programmable number of host clocks. During that stretch the bus-request strap is driven low. After the processor reset goes high, the strap stays low for a bounded number of clocks and is then released to the board pull-up by dropping its output enable.

A separate, power-good-driven path captures the 2-bit bus-frequency select strap once per power-up. It reports the chosen code and raises a flag if the strap holds the reserved value. The stretch length `STRETCH_CYC` and the strap hold length `HOLD_CYC` are parameters counted in host clocks. For example, about 1 ms at the host clock rate suits the stretch.

Top module: `cpu_reset_seq`

## Requirements
- R1: While `plat_rst_n` is low, `cpu_rst_n` is low. It follows the falling edge of `plat_rst_n` with no clock edge needed.
- R2: `plat_rst_n` is synchronized through two flops. After it rises between two clock edges, `cpu_rst_n` stays low through the next `STRETCH_CYC`+1 rising edges. It goes high on the (`STRETCH_CYC`+2)-th edge.
- R3: Whenever `cpu_rst_n` is low, the strap is driven low (`breq_oe`=1, `breq_n`=0). `STRETCH_CYC` below 4 is rejected at elaboration, so the strap leads the reset release by at least 4 clocks.
- R4: After `cpu_rst_n` rises, the strap stays driven low for exactly `HOLD_CYC` clocks. It then becomes `breq_oe`=0 with `breq_n`=1. `HOLD_CYC` outside 2..20 is rejected at elaboration.
- R5: If `plat_rst_n` is asserted again at any point in the sequence, `cpu_rst_n` goes low at once and the strap is driven low again. On the next release the full stretch and hold repeat from the start.
- R6: `freq_sel` is latched into `freq_code` on the third rising clock edge after `pwr_good` rises. Code 00 means 100 MHz core / 400 MHz bus, 01 means 133/533, and 10 means 200/800; each is passed through unchanged. Later changes of `freq_sel` have no effect until the next power-good cycle.
- R7: A latched value of 11 is reserved. It yields `freq_code`=00 with `freq_rsvd`=1, and the flag stays set until `pwr_good` falls. While `pwr_good` is low, `freq_code` is 00 and `freq_rsvd` is 0.
- R8: The platform reset does not disturb `freq_code` or `freq_rsvd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| plat_rst_n | input | 1 | Platform reset, active low, asynchronous |
| pwr_good | input | 1 | Power good; its rising edge latches the frequency strap |
| freq_sel | input | 2 | Bus-frequency select strap |
| cpu_rst_n | output | 1 | Processor reset, active low |
| breq_n | output | 1 | Bus-request strap value |
| breq_oe | output | 1 | Output enable for the bus-request strap |
| freq_code | output | 2 | Latched frequency code |
| freq_rsvd | output | 1 | Sticky flag for a reserved strap code |

## Verification
A stretch counter that is off by one shows up as a processor reset release one clock early or late. This is visible on the first release after reset. A wrong hold count changes the number of clocks between the rise of `cpu_rst_n` and the fall of `breq_oe`. A counter that is not cleared on a second platform reset shows as a shortened stretch on the release that follows. Reassertion is therefore swept across every clock of the sequence. A mis-timed or unreset frequency latch shows within three clocks of power-good rising, either as the wrong code or as a flag that does not clear.

// File: rtl/cpu_reset_seq.sv
module cpu_reset_seq #(
  parameter int STRETCH_CYC = 250000,
  parameter int HOLD_CYC    = 10
) (
  input  logic       clk,
  input  logic       plat_rst_n,
  input  logic       pwr_good,
  input  logic [1:0] freq_sel,
  output logic       cpu_rst_n,
  output logic       breq_n,
  output logic       breq_oe,
  output logic [1:0] freq_code,
  output logic       freq_rsvd
);
  localparam int SW = $clog2(STRETCH_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);

  if (HOLD_CYC < 2 || HOLD_CYC > 20) begin : g_bad_hold
    $error("HOLD_CYC must lie in 2..20");
  end
  if (STRETCH_CYC < 4) begin : g_bad_stretch
    $error("STRETCH_CYC must be at least 4");
  end

  logic [1:0]    sync_q;
  logic [SW-1:0] stretch_q;
  logic [HW-1:0] hold_q;
  logic          cpu_up_q, strap_done_q;

  always_ff @(posedge clk or negedge plat_rst_n) begin
    if (!plat_rst_n) begin
      sync_q       <= '0;
      stretch_q    <= '0;
      hold_q       <= '0;
      cpu_up_q     <= 1'b0;
      strap_done_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
      if (!sync_q[1]) begin
        stretch_q    <= '0;
        hold_q       <= '0;
        cpu_up_q     <= 1'b0;
        strap_done_q <= 1'b0;
      end else if (!cpu_up_q) begin
        if (stretch_q == SW'(STRETCH_CYC - 1)) cpu_up_q <= 1'b1;
        else stretch_q <= stretch_q + SW'(1);
      end else if (!strap_done_q) begin
        if (hold_q == HW'(HOLD_CYC - 1)) strap_done_q <= 1'b1;
        else hold_q <= hold_q + HW'(1);
      end
    end
  end

  assign cpu_rst_n = cpu_up_q;
  assign breq_n    = strap_done_q;
  assign breq_oe   = ~strap_done_q;

  logic [2:0] pg_q;
  wire        pg_rise  = pg_q[1] & ~pg_q[2];
  wire        rsvd_sel = (freq_sel == 2'b11);

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      pg_q      <= '0;
      freq_code <= 2'b00;
      freq_rsvd <= 1'b0;
    end else begin
      pg_q <= {pg_q[1:0], 1'b1};
      if (pg_rise) begin
        freq_code <= rsvd_sel ? 2'b00 : freq_sel;
        freq_rsvd <= rsvd_sel;
      end
    end
  end
endmodule

module cpu_reset_seq_chk #(
  parameter int STRETCH_CYC = 250000,
  parameter int HOLD_CYC    = 10
) (
  input logic       clk,
  input logic       plat_rst_n,
  input logic       pwr_good,
  input logic       cpu_rst_n,
  input logic       breq_n,
  input logic       breq_oe,
  input logic [1:0] freq_code,
  input logic       freq_rsvd
);
  int low_n, hold_n;

  always_ff @(posedge clk or negedge plat_rst_n) begin
    if (!plat_rst_n) begin
      low_n  <= 0;
      hold_n <= 0;
    end else begin
      if (!cpu_rst_n) low_n <= low_n + 1;
      if (cpu_rst_n && breq_oe) hold_n <= hold_n + 1;
    end
  end

  p_rst_follow_r1: assert property (@(posedge clk) !plat_rst_n |-> !cpu_rst_n);
  p_stretch_len_r2: assert property (@(posedge clk) disable iff (!plat_rst_n)
    $rose(cpu_rst_n) |-> low_n >= STRETCH_CYC);
  p_strap_in_rst_r3: assert property (@(posedge clk) disable iff (!plat_rst_n)
    !cpu_rst_n |-> (breq_oe && !breq_n));
  p_setup_min_r3: assert property (@(posedge clk) disable iff (!plat_rst_n)
    $rose(cpu_rst_n) |-> low_n >= 4);
  p_hold_max_r4: assert property (@(posedge clk) disable iff (!plat_rst_n)
    hold_n <= 20);
  p_hold_min_r4: assert property (@(posedge clk) disable iff (!plat_rst_n)
    $fell(breq_oe) |-> hold_n >= 2);
  p_code_legal_r7: assert property (@(posedge clk) disable iff (!pwr_good)
    freq_code != 2'b11);
  p_rsvd_sticky_r7: assert property (@(posedge clk) disable iff (!pwr_good)
    freq_rsvd |=> freq_rsvd);
endmodule

bind cpu_reset_seq cpu_reset_seq_chk #(.STRETCH_CYC(STRETCH_CYC), .HOLD_CYC(HOLD_CYC)) u_chk (.*);

// File: tb/cpu_reset_seq_tb.sv
module cpu_reset_seq_tb;
  localparam int S = 8;
  localparam int H = 5;

  logic       clk = 1'b0;
  logic       plat_rst_n, pwr_good;
  logic [1:0] freq_sel;
  logic       cpu_rst_n, breq_n, breq_oe, freq_rsvd;
  logic [1:0] freq_code;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  cpu_reset_seq #(.STRETCH_CYC(S), .HOLD_CYC(H)) u_dut (
    .clk(clk), .plat_rst_n(plat_rst_n), .pwr_good(pwr_good), .freq_sel(freq_sel),
    .cpu_rst_n(cpu_rst_n), .breq_n(breq_n), .breq_oe(breq_oe),
    .freq_code(freq_code), .freq_rsvd(freq_rsvd));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Release platform reset at a negedge and measure stretch and hold lengths.
  task automatic run_seq();
    int lowc = 0, holdc = 0, strap_bad = 0;
    plat_rst_n = 1'b1;
    while (!cpu_rst_n && lowc < 100) begin
      @(negedge clk);
      if (!cpu_rst_n) begin
        lowc++;
        if (breq_n !== 1'b0 || breq_oe !== 1'b1) strap_bad++;
      end
    end
    chk("R2 stretch samples", lowc, S + 1);
    chk("R3 strap low during stretch", strap_bad, 0);
    while (breq_oe && holdc < 100) begin
      holdc++;
      if (breq_n !== 1'b0) strap_bad++;
      @(negedge clk);
    end
    chk("R4 hold clocks", holdc, H);
    chk("R4 strap released value", int'(breq_n), 1);
    chk("R4 cpu reset stays high", int'(cpu_rst_n), 1);
  endtask

  initial begin
    plat_rst_n = 1'b0;
    pwr_good   = 1'b0;
    freq_sel   = 2'b00;
    repeat (3) @(negedge clk);
    chk("R1 reset cpu_rst_n", int'(cpu_rst_n), 0);
    chk("R3 reset breq_n", int'(breq_n), 0);
    chk("R3 reset breq_oe", int'(breq_oe), 1);
    chk("R7 reset freq_code", int'(freq_code), 0);
    chk("R7 reset freq_rsvd", int'(freq_rsvd), 0);

    for (int c = 0; c < 4; c++) begin
      pwr_good = 1'b0;
      #1;
      chk("R7 pg low clears code", int'(freq_code), 0);
      chk("R7 pg low clears flag", int'(freq_rsvd), 0);
      freq_sel = 2'(c);
      @(negedge clk);
      pwr_good = 1'b1;
      repeat (2) @(negedge clk);
      chk("R6 no capture before third edge", int'(freq_code), 0);
      @(negedge clk);
      chk("R6 captured code", int'(freq_code), (c == 3) ? 0 : c);
      chk("R7 reserved flag", int'(freq_rsvd), (c == 3) ? 1 : 0);
      freq_sel = ~2'(c);
      repeat (5) @(negedge clk);
      chk("R6 later strap ignored", int'(freq_code), (c == 3) ? 0 : c);
      chk("R7 flag sticky", int'(freq_rsvd), (c == 3) ? 1 : 0);
    end

    pwr_good = 1'b0;
    freq_sel = 2'b01;
    @(negedge clk);
    pwr_good = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 code 01", int'(freq_code), 1);

    run_seq();
    for (int k = 0; k < S + H + 4; k++) begin
      plat_rst_n = 1'b0;
      repeat (3) @(negedge clk);
      plat_rst_n = 1'b1;
      repeat (k) @(negedge clk);
      #1 plat_rst_n = 1'b0;
      #1;
      chk("R5 reassert cpu low at once", int'(cpu_rst_n), 0);
      chk("R5 reassert strap driven", int'(breq_oe), 1);
      chk("R5 reassert strap low", int'(breq_n), 0);
      repeat (2) @(negedge clk);
      chk("R8 code kept through reset", int'(freq_code), 1);
      chk("R8 flag kept through reset", int'(freq_rsvd), 0);
      run_seq();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule